// File: doc/BRIEF.md
# Erase-Block Locator and Write Guard

This block turns the upper seven bits of a word address (the 4-kword region number, address bits 18 down to 12) into the index of one of nineteen erase blocks. A parameter chooses one of two mirror-image layouts. In each layout the small blocks are gathered at one end of the address space: one 8-kword boot block, two 4-kword parameter blocks and one 16-kword block. The remaining fifteen blocks are 32-kword main blocks. Block 0 is always the block at the lowest address. The block reports the index and the size of the block that is addressed.

The block also holds one lock flag per erase block, kept in registers. A flag of 1 means unlocked and 0 means locked. Each program or erase attempt is judged against that flag and against three further inputs. The first is a master protect pin. When it is high, the flags are ignored. The second is a high-voltage reset indication, which overrides every lock. The third is a powerdown indication, under which every block counts as locked. A refused attempt raises a violation flag. A separate read port returns the flag of any block on data bit 6.

Top module: `boot_blk_guard`

## Requirements
- R1: With BOOT_TOP=1, region numbers 0x00-0x77 map to index region>>3 as 32-kword blocks. 0x78-0x7B map to index 15 (16 kword). 0x7C maps to 16 and 0x7D maps to 17 (4 kword each). 0x7E-0x7F map to 18 (8 kword).
- R2: With BOOT_TOP=0, 0x00-0x01 map to index 0 (8 kword). 0x02 maps to 1 and 0x03 maps to 2 (4 kword each). 0x04-0x07 map to 3 (16 kword). Every region from 0x08 upward maps to (region>>3)+3 as a 32-kword block.
- R3: `blk_size_o` gives the block size in kwords (4, 8, 16 or 32).
- R4: `blk_idx_o` and `blk_size_o` are registered and follow `blk_addr_i` one clock later. After reset both read 0, and `viol_o` and `lock_rd_o` also read 0.
- R5: Reset sets all lock flags to 1 (unlocked).
- R6: A `lock_set_i` pulse clears the flag of the addressed block to 0. This happens even when protection is off, unless powerdown is active.
- R7: The clock after `rd_idx_i` is presented, `lock_rd_o` shows that block's flag on bit 6 with all other bits 0. An index of 19 or more reads 0x00.
- R8: With `wp_i`=0, `hv_i`=0 and `pd_i`=0, an `op_req_i` to a block whose flag is 0 raises `viol_o` on the next clock. An `op_req_i` to a block whose flag is 1 does not.
- R9: With `wp_i`=1 or `hv_i`=1 (and `pd_i`=0), no `op_req_i` raises `viol_o`, whatever the flag.
- R10: `erase_done_i` sets the addressed block's flag to 1 only when that block is writable. A refused erase leaves the flag unchanged.
- R11: While `pd_i`=1, every `op_req_i` raises `viol_o`, lock reads return 0x00, and no flag changes.
- R12: An attempt is judged against the flags as they stood before the clock edge on which it is sampled. When `lock_set_i` and `erase_done_i` arrive together, the lock wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset of the model; restores all flags to unlocked |
| blk_addr_i | input | 7 | Word address bits 18..12 |
| wp_i | input | 1 | Master protect pin; 0 enforces lock flags |
| hv_i | input | 1 | High-voltage reset indication; unlocks everything |
| pd_i | input | 1 | Powerdown (reset pin low); everything locked |
| op_req_i | input | 1 | Program or erase attempt to the addressed block |
| lock_set_i | input | 1 | Lock the addressed block |
| erase_done_i | input | 1 | Erase of the addressed block completed |
| rd_idx_i | input | 5 | Block index for lock reads |
| blk_idx_o | output | 5 | Registered block index |
| blk_size_o | output | 6 | Registered block size in kwords |
| lock_rd_o | output | 8 | Lock read data, flag on bit 6 |
| viol_o | output | 1 | Registered protect violation |

## Verification
A lock or erase update and a permission check can fall on the same clock edge for the same block. A further collision is a lock and an erase arriving together. The bench drives `lock_set_i` together with `op_req_i` at the boot block while protection is enforced. It expects no violation on that attempt and a violation on the next attempt, which shows that the old flag governs. It then raises `lock_set_i` and `erase_done_i` together and reads the flag back through `lock_rd_o`, expecting 0.

// File: rtl/boot_blk_pkg.sv
package boot_blk_pkg;
    localparam int unsigned NBLK      = 19;
    localparam int unsigned ADDR_W    = 7;
    localparam int unsigned IDX_W     = $clog2(NBLK);
    localparam int unsigned SIZE_W    = 6;
    localparam int unsigned DATA_W    = 8;
    localparam int unsigned LOCK_POS  = 6;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [SIZE_W-1:0] size;
        logic [DATA_W-1:0] rd;
        logic              viol;
    } guard_st_t;
endpackage

// File: rtl/bbl_addr_map.sv
module bbl_addr_map #(
    parameter bit          BOOT_TOP = 1'b1,
    parameter int unsigned ADDR_W   = 7,
    parameter int unsigned IDX_W    = 5,
    parameter int unsigned SIZE_W   = 6
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic [SIZE_W-1:0] size_o
);
    localparam int unsigned HI_W    = ADDR_W - 3;
    localparam int unsigned REGIONS = 2 ** HI_W;
    localparam int unsigned SMALL   = 4;
    localparam logic [SIZE_W-1:0] SZ_MAIN  = SIZE_W'(32);
    localparam logic [SIZE_W-1:0] SZ_HALF  = SIZE_W'(16);
    localparam logic [SIZE_W-1:0] SZ_BOOT  = SIZE_W'(8);
    localparam logic [SIZE_W-1:0] SZ_PARAM = SIZE_W'(4);

    logic [HI_W-1:0] hi;
    logic [2:0]      lo;
    assign hi = addr_i[ADDR_W-1:3];
    assign lo = addr_i[2:0];

    generate
        if (BOOT_TOP) begin : g_top
            always_comb begin
                if (hi != HI_W'(REGIONS - 1)) begin
                    idx_o  = IDX_W'(hi);
                    size_o = SZ_MAIN;
                end else if (!lo[2]) begin
                    idx_o  = IDX_W'(REGIONS - 1);
                    size_o = SZ_HALF;
                end else if (!lo[1]) begin
                    idx_o  = IDX_W'(REGIONS) + IDX_W'(lo[0]);
                    size_o = SZ_PARAM;
                end else begin
                    idx_o  = IDX_W'(REGIONS + 2);
                    size_o = SZ_BOOT;
                end
            end
        end else begin : g_bottom
            always_comb begin
                if (hi != '0) begin
                    idx_o  = IDX_W'(hi) + IDX_W'(SMALL - 1);
                    size_o = SZ_MAIN;
                end else if (lo[2]) begin
                    idx_o  = IDX_W'(SMALL - 1);
                    size_o = SZ_HALF;
                end else if (lo[1]) begin
                    idx_o  = IDX_W'(1) + IDX_W'(lo[0]);
                    size_o = SZ_PARAM;
                end else begin
                    idx_o  = '0;
                    size_o = SZ_BOOT;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/bbl_lock_store.sv
module bbl_lock_store #(
    parameter int unsigned NBLK  = 19,
    parameter int unsigned IDX_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pd_i,
    input  logic             set_i,
    input  logic             clr_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic             wr_bit_o,
    output logic             rd_bit_o
);
    typedef struct packed {
        logic [NBLK-1:0] bits;
    } lock_st_t;

    lock_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!pd_i) begin
            if (set_i)
                st_d.bits[wr_idx_i] = 1'b0;
            else if (clr_i)
                st_d.bits[wr_idx_i] = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{bits: '1};
        else         st_q <= st_d;
    end

    assign wr_bit_o = (wr_idx_i < IDX_W'(NBLK)) ? st_q.bits[wr_idx_i] : 1'b0;
    assign rd_bit_o = (rd_idx_i < IDX_W'(NBLK)) ? st_q.bits[rd_idx_i] : 1'b0;

    assert_lock_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i && !pd_i |=> !st_q.bits[$past(wr_idx_i)]);
    assert_erase_unlock_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i && !set_i && !pd_i |=> st_q.bits[$past(wr_idx_i)]);
    assert_pd_frozen_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pd_i |=> $stable(st_q.bits));
endmodule

// File: rtl/bbl_permit.sv
module bbl_permit (
    input  logic pd_i,
    input  logic hv_i,
    input  logic wp_i,
    input  logic lock_bit_i,
    output logic allow_o
);
    always_comb begin
        if (pd_i)                    allow_o = 1'b0;
        else if (hv_i || wp_i)       allow_o = 1'b1;
        else                         allow_o = lock_bit_i;
    end
endmodule

// File: rtl/boot_blk_guard.sv
module boot_blk_guard
    import boot_blk_pkg::*;
#(
    parameter bit BOOT_TOP = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] blk_addr_i,
    input  logic              wp_i,
    input  logic              hv_i,
    input  logic              pd_i,
    input  logic              op_req_i,
    input  logic              lock_set_i,
    input  logic              erase_done_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [IDX_W-1:0]  blk_idx_o,
    output logic [SIZE_W-1:0] blk_size_o,
    output logic [DATA_W-1:0] lock_rd_o,
    output logic              viol_o
);
    logic [IDX_W-1:0]  idx_c;
    logic [SIZE_W-1:0] size_c;
    logic              wr_bit, rd_bit, allow;
    guard_st_t         st_d, st_q;

    bbl_addr_map #(
        .BOOT_TOP(BOOT_TOP), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .SIZE_W(SIZE_W)
    ) i_map (
        .addr_i(blk_addr_i), .idx_o(idx_c), .size_o(size_c)
    );

    bbl_lock_store #(.NBLK(NBLK), .IDX_W(IDX_W)) i_store (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .pd_i     (pd_i),
        .set_i    (lock_set_i),
        .clr_i    (erase_done_i && allow),
        .wr_idx_i (idx_c),
        .rd_idx_i (rd_idx_i),
        .wr_bit_o (wr_bit),
        .rd_bit_o (rd_bit)
    );

    bbl_permit i_permit (
        .pd_i(pd_i), .hv_i(hv_i), .wp_i(wp_i), .lock_bit_i(wr_bit), .allow_o(allow)
    );

    always_comb begin
        st_d      = st_q;
        st_d.idx  = idx_c;
        st_d.size = size_c;
        st_d.viol = op_req_i && !allow;
        st_d.rd   = '0;
        if (!pd_i)
            st_d.rd[LOCK_POS] = rd_bit;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign blk_idx_o  = st_q.idx;
    assign blk_size_o = st_q.size;
    assign lock_rd_o  = st_q.rd;
    assign viol_o     = st_q.viol;

    assert_idx_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        blk_idx_o < IDX_W'(NBLK));
    assert_locked_refused_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        op_req_i && !pd_i && !wp_i && !hv_i && !wr_bit |=> viol_o);
    assert_override_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        op_req_i && !pd_i && (wp_i || hv_i) |=> !viol_o);
    assert_pd_refused_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pd_i && op_req_i |=> viol_o);
    assert_pd_read_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pd_i |=> lock_rd_o == '0);
    assert_viol_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        viol_o |-> $past(op_req_i));
endmodule

// File: tb/test_boot_blk_guard.sv
module test_boot_blk_guard;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] addr = '0;
    logic       wp = 1'b0, hv = 1'b0, pd = 1'b0, req = 1'b0, lset = 1'b0, edone = 1'b0;
    logic [4:0] ridx = '0;
    logic [4:0] idx_t, idx_b;
    logic [5:0] sz_t, sz_b;
    logic [7:0] rd_t, rd_b;
    logic       v_t, v_b;
    int         n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    boot_blk_guard #(.BOOT_TOP(1'b1)) i_boot_blk_guard (
        .clk_i(clk), .rst_ni(rst_n), .blk_addr_i(addr), .wp_i(wp), .hv_i(hv),
        .pd_i(pd), .op_req_i(req), .lock_set_i(lset), .erase_done_i(edone),
        .rd_idx_i(ridx), .blk_idx_o(idx_t), .blk_size_o(sz_t),
        .lock_rd_o(rd_t), .viol_o(v_t));

    boot_blk_guard #(.BOOT_TOP(1'b0)) i_boot_blk_guard_bot (
        .clk_i(clk), .rst_ni(rst_n), .blk_addr_i(addr), .wp_i(wp), .hv_i(hv),
        .pd_i(pd), .op_req_i(req), .lock_set_i(lset), .erase_done_i(edone),
        .rd_idx_i(ridx), .blk_idx_o(idx_b), .blk_size_o(sz_b),
        .lock_rd_o(rd_b), .viol_o(v_b));

    // {region, top idx, top size, bottom idx, bottom size}
    localparam logic [28:0] VEC [15] = '{
        {7'h00, 5'd0,  6'd32, 5'd0,  6'd8 },
        {7'h01, 5'd0,  6'd32, 5'd0,  6'd8 },
        {7'h02, 5'd0,  6'd32, 5'd1,  6'd4 },
        {7'h03, 5'd0,  6'd32, 5'd2,  6'd4 },
        {7'h04, 5'd0,  6'd32, 5'd3,  6'd16},
        {7'h07, 5'd0,  6'd32, 5'd3,  6'd16},
        {7'h08, 5'd1,  6'd32, 5'd4,  6'd32},
        {7'h3C, 5'd7,  6'd32, 5'd10, 6'd32},
        {7'h70, 5'd14, 6'd32, 5'd17, 6'd32},
        {7'h78, 5'd15, 6'd16, 5'd18, 6'd32},
        {7'h7B, 5'd15, 6'd16, 5'd18, 6'd32},
        {7'h7C, 5'd16, 6'd4,  5'd18, 6'd32},
        {7'h7D, 5'd17, 6'd4,  5'd18, 6'd32},
        {7'h7E, 5'd18, 6'd8,  5'd18, 6'd32},
        {7'h7F, 5'd18, 6'd8,  5'd18, 6'd32}
    };

    task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        #1;
    endtask

    task automatic idle;
        req = 1'b0; lset = 1'b0; edone = 1'b0;
    endtask

    task automatic read_lock(input logic [4:0] i, input logic [7:0] exp, input string tag);
        idle();
        ridx = i;
        step();
        chk(tag, 32'(rd_t), 32'(exp));
    endtask

    task automatic attempt(input logic [6:0] a, input logic exp, input string tag);
        idle();
        addr = a; req = 1'b1;
        step();
        chk(tag, 32'(v_t), 32'(exp));
        req = 1'b0;
    endtask

    initial begin
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R4 reset idx", 32'(idx_t), 0);
        chk("R4 reset size", 32'(sz_t), 0);
        chk("R4 reset viol", 32'(v_t), 0);
        chk("R4 reset lock read", 32'(rd_t), 0);
        rst_n = 1'b1;
        ridx = 5'd0;
        step();
        chk("R5 unlocked after reset", 32'(rd_t), 32'h40);

        // R1 R2 R3 R4: vector walk
        foreach (VEC[k]) begin
            addr = VEC[k][28:22];
            step();
            chk("R1 top idx", 32'(idx_t), 32'(VEC[k][21:17]));
            chk("R3 top size", 32'(sz_t), 32'(VEC[k][16:11]));
            chk("R2 bottom idx", 32'(idx_b), 32'(VEC[k][10:6]));
            chk("R3 bottom size", 32'(sz_b), 32'(VEC[k][5:0]));
        end

        // R6: lock block 16, neighbour untouched
        idle(); addr = 7'h7C; lset = 1'b1; step(); idle();
        read_lock(5'd16, 8'h00, "R6 locked flag");
        read_lock(5'd17, 8'h40, "R6 neighbour unlocked");
        read_lock(5'd25, 8'h00, "R7 out of range");

        // R8 / R9
        attempt(7'h7C, 1'b1, "R8 locked refused");
        attempt(7'h7D, 1'b0, "R8 unlocked accepted");
        wp = 1'b1; attempt(7'h7C, 1'b0, "R9 protect pin high"); wp = 1'b0;
        hv = 1'b1; attempt(7'h7C, 1'b0, "R9 high voltage"); hv = 1'b0;

        // R10
        idle(); addr = 7'h7C; edone = 1'b1; step(); idle();
        read_lock(5'd16, 8'h00, "R10 refused erase keeps lock");
        wp = 1'b1; addr = 7'h7C; edone = 1'b1; step(); idle(); wp = 1'b0;
        read_lock(5'd16, 8'h40, "R10 erase unlocks");

        // R11
        pd = 1'b1;
        attempt(7'h7D, 1'b1, "R11 powerdown refuses");
        hv = 1'b1; attempt(7'h7D, 1'b1, "R11 powerdown beats hv"); hv = 1'b0;
        read_lock(5'd17, 8'h00, "R11 powerdown read");
        addr = 7'h7D; lset = 1'b1; step(); idle();
        pd = 1'b0;
        read_lock(5'd17, 8'h40, "R11 lock ignored in powerdown");

        // R12: same-edge lock and attempt
        idle(); addr = 7'h7E; lset = 1'b1; req = 1'b1; step();
        chk("R12 old flag governs", 32'(v_t), 0);
        attempt(7'h7E, 1'b1, "R12 new flag governs");
        wp = 1'b1; idle(); addr = 7'h7D; lset = 1'b1; edone = 1'b1; step(); idle(); wp = 1'b0;
        read_lock(5'd17, 8'h00, "R12 lock wins over erase");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule